// File: doc/BRIEF.md
# Motion-Adaptive Field Interpolation Selector

This block sits in a field-rate doubling path. It watches the luminance of two field channels, A and B, arriving side by side on a pixel clock. From them it grades how much the picture is moving. The output field rate is twice the input field rate, and the block uses the motion grade to choose the interpolation scheme that builds the extra fields. Colour information plays no part in the decision.

The absolute luminance difference between A and B is summed over the active samples of a whole frame, which is two input fields. At each frame boundary the sum is placed against two programmable thresholds to give one of three levels. Three configuration inputs say which interpolation code goes with each level, and the block applies the matching code on its own. It also measures the number of lines between vertical syncs. When that count jumps by more than a programmable tolerance, the block falls back to plain field repetition (AABB) until the count has settled again. Software can also force the fallback mode directly.

Top module: `field_interp_select`

## Requirements
- R1: The motion sum adds |lumaA − lumaB| on every clock with hBlank low, starting from the first vSync after reset, and is cleared at each frame boundary. It covers the two fields of one frame and saturates at its all-ones value.
- R2: At a frame boundary, a sum below thrLow gives motionLevel 2'b00 (LOW). A sum at or above thrHigh, while not below thrLow, gives 2'b10 (HIGH). Any other sum gives 2'b01 (MEDIUM). The code 2'b11 never appears on motionLevel.
- R3: A frame boundary is the 1st, 3rd, 5th and each later odd-numbered vSync pulse after reset. motionLevel changes only on the clock after a boundary pulse and holds its value between boundaries.
- R4: When no fallback is active, modeCode equals mapLow, mapMed or mapHigh for a motionLevel of LOW, MEDIUM or HIGH respectively. The map inputs act combinationally.
- R5: Whenever fallback is high, modeCode is 2'b11, and this takes priority over every mapped code.
- R6: A line is counted at each rising edge of hBlank. At each vSync from the second onward, the line count of the interval just ended is compared with the count of the interval before it. If they differ by more than lineTol, the sync is marked unstable on the next clock, and fallback is raised.
- R7: Once the sync is unstable, it becomes stable again only at the second of two consecutive intervals that each lie within lineTol of the interval before. The sync is taken as stable out of reset.
- R8: forceFb high drives fallback high and modeCode to 2'b11 in the same cycle, whatever the motion level or sync state.
- R9: After reset, motionLevel is LOW and fallback is high. Fallback stays high until the clock after the first boundary that closes a fully measured frame, which is the third vSync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lumaA | input | LUMA_W | Luminance sample of channel A |
| lumaB | input | LUMA_W | Luminance sample of channel B |
| vSync | input | 1 | One-clock pulse at the start of each input field |
| hBlank | input | 1 | High during line blanking, low on active samples |
| forceFb | input | 1 | Forces the repeated-field fallback mode |
| thrLow | input | SUM_W | Lower motion threshold |
| thrHigh | input | SUM_W | Upper motion threshold |
| lineTol | input | LINE_W | Allowed line-count change between intervals |
| mapLow | input | 2 | Interpolation code for LOW motion |
| mapMed | input | 2 | Interpolation code for MEDIUM motion |
| mapHigh | input | 2 | Interpolation code for HIGH motion |
| motionLevel | output | 2 | Graded motion: 00 LOW, 01 MEDIUM, 10 HIGH |
| modeCode | output | 2 | Selected interpolation code, 11 in fallback |
| fallback | output | 1 | Repeated-field fallback is active |

## Verification
The frame-boundary grading and the sync-stability judgement both act on the same vSync pulse. A line-count step can therefore land on the very boundary that also changes the motion level. The bench provokes this with a frame whose second field carries an extra line and high luminance difference. It then checks that the new level appears on motionLevel while modeCode still shows the fallback code. The bench also sets the thresholds to exactly the accumulated sum just before a boundary, which probes both comparison edges. A forced fallback raised in mid-field is judged in the same cycle, against a bench model that has no knowledge of the grading state.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MED  = 2'b01,
    LVL_HIGH = 2'b10
  } motion_e;

  localparam logic [1:0] CODE_FALLBACK = 2'b11;

  typedef struct packed {
    logic accEn;
    logic accClr;
    logic frameLatch;
  } strobe_t;
endpackage

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import fis_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vSync,
  input  logic              hBlank,
  input  logic [LINE_W-1:0] lineTol,
  output strobe_t           stb,
  output logic              syncStable,
  output logic              measValid
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [1:0]        RUN_MAX  = 2'd3;

  logic              started;
  logic              phase;
  logic              havePrev;
  logic              hBlankQ;
  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] prevCnt;
  logic [LINE_W-1:0] countDiff;
  logic [1:0]        matchRun;
  logic              lineEnd;
  logic              withinTol;

  assign lineEnd   = hBlank & ~hBlankQ;
  assign countDiff = (lineCnt >= prevCnt) ? (lineCnt - prevCnt) : (prevCnt - lineCnt);
  assign withinTol = (countDiff <= lineTol);

  always_comb begin
    stb.accEn      = started & ~hBlank;
    stb.accClr     = vSync & ~phase;
    stb.frameLatch = vSync & ~phase & started;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started    <= 1'b0;
      phase      <= 1'b0;
      havePrev   <= 1'b0;
      hBlankQ    <= 1'b1;
      lineCnt    <= '0;
      prevCnt    <= '0;
      matchRun   <= '0;
      syncStable <= 1'b1;
      measValid  <= 1'b0;
    end else begin
      hBlankQ <= hBlank;
      if (vSync) begin
        lineCnt <= '0;
        phase   <= ~phase;
        started <= 1'b1;
        if (started) begin
          prevCnt  <= lineCnt;
          havePrev <= 1'b1;
          if (havePrev) begin
            if (!withinTol) begin
              syncStable <= 1'b0;
              matchRun   <= '0;
            end else begin
              if (matchRun != RUN_MAX) matchRun <= matchRun + 2'd1;
              if (matchRun >= 2'd1) syncStable <= 1'b1;
            end
          end
        end
      end else if (lineEnd && lineCnt != LINE_MAX) begin
        lineCnt <= lineCnt + 1'b1;
      end
      if (stb.frameLatch) measValid <= 1'b1;
    end
  end
endmodule

// File: rtl/fis_datapath.sv
module fis_datapath
  import fis_pkg::*;
#(
  parameter int LUMA_W   = 8,
  parameter int SUM_W    = 20,
  parameter bit SATURATE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LUMA_W-1:0] lumaA,
  input  logic [LUMA_W-1:0] lumaB,
  input  strobe_t           stb,
  input  logic [SUM_W-1:0]  thrLow,
  input  logic [SUM_W-1:0]  thrHigh,
  output motion_e           level
);
  localparam int PAD_W = SUM_W + 1 - LUMA_W;

  logic [LUMA_W-1:0] absDiff;
  logic [SUM_W:0]    sumWide;
  logic [SUM_W-1:0]  acc;
  logic [SUM_W-1:0]  accNext;
  motion_e           graded;

  assign absDiff = (lumaA >= lumaB) ? (lumaA - lumaB) : (lumaB - lumaA);
  assign sumWide = {1'b0, acc} + {{PAD_W{1'b0}}, absDiff};

  generate
    if (SATURATE) begin : g_sat
      assign accNext = sumWide[SUM_W] ? {SUM_W{1'b1}} : sumWide[SUM_W-1:0];
    end else begin : g_wrap
      assign accNext = sumWide[SUM_W-1:0];
    end
  endgenerate

  always_comb begin
    if (acc < thrLow)        graded = LVL_LOW;
    else if (acc >= thrHigh) graded = LVL_HIGH;
    else                     graded = LVL_MED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      level <= LVL_LOW;
    end else begin
      if (stb.frameLatch) level <= graded;
      if (stb.accClr)     acc <= '0;
      else if (stb.accEn) acc <= accNext;
    end
  end
endmodule

// File: rtl/field_interp_select.sv
module field_interp_select
  import fis_pkg::*;
#(
  parameter int LUMA_W = 8,
  parameter int SUM_W  = 20,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LUMA_W-1:0] lumaA,
  input  logic [LUMA_W-1:0] lumaB,
  input  logic              vSync,
  input  logic              hBlank,
  input  logic              forceFb,
  input  logic [SUM_W-1:0]  thrLow,
  input  logic [SUM_W-1:0]  thrHigh,
  input  logic [LINE_W-1:0] lineTol,
  input  logic [1:0]        mapLow,
  input  logic [1:0]        mapMed,
  input  logic [1:0]        mapHigh,
  output logic [1:0]        motionLevel,
  output logic [1:0]        modeCode,
  output logic              fallback
);
  strobe_t stb;
  logic    syncStable;
  logic    measValid;
  motion_e level;
  logic [1:0] mapped;

  fis_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .vSync(vSync), .hBlank(hBlank), .lineTol(lineTol),
    .stb(stb), .syncStable(syncStable), .measValid(measValid)
  );

  fis_datapath #(.LUMA_W(LUMA_W), .SUM_W(SUM_W), .SATURATE(1'b1)) u_dp (
    .clk(clk), .rstN(rstN), .lumaA(lumaA), .lumaB(lumaB), .stb(stb),
    .thrLow(thrLow), .thrHigh(thrHigh), .level(level)
  );

  always_comb begin
    case (level)
      LVL_MED:  mapped = mapMed;
      LVL_HIGH: mapped = mapHigh;
      default:  mapped = mapLow;
    endcase
  end

  assign motionLevel = level;
  assign fallback    = forceFb | ~syncStable | ~measValid;
  assign modeCode    = fallback ? CODE_FALLBACK : mapped;
endmodule

// File: rtl/fis_chk.sv
module fis_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vSync,
  input logic       forceFb,
  input logic [1:0] motionLevel,
  input logic [1:0] modeCode,
  input logic       fallback,
  input logic       frameLatch,
  input logic       syncStable,
  input logic       measValid
);
  assert_level_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    motionLevel != 2'b11);

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !frameLatch |=> $stable(motionLevel));

  assert_fb_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    fallback |-> modeCode == 2'b11);

  assert_unstable_fb_R6: assert property (@(posedge clk) disable iff (!rstN)
    !syncStable |-> fallback);

  assert_restable_vsync_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncStable) |-> $past(vSync));

  assert_force_R8: assert property (@(posedge clk) disable iff (!rstN)
    forceFb |-> (fallback && modeCode == 2'b11));

  assert_unmeasured_fb_R9: assert property (@(posedge clk) disable iff (!rstN)
    !measValid |-> fallback);
endmodule

bind field_interp_select fis_chk u_fis_chk (
  .clk(clk), .rstN(rstN), .vSync(vSync), .forceFb(forceFb),
  .motionLevel(motionLevel), .modeCode(modeCode), .fallback(fallback),
  .frameLatch(stb.frameLatch), .syncStable(syncStable), .measValid(measValid)
);

// File: tb/field_interp_select_test.sv
`timescale 1ns/1ps
module field_interp_select_test;
  localparam int LUMA_W = 8;
  localparam int SUM_W  = 20;
  localparam int LINE_W = 10;
  localparam int ACTIVE = 16;
  localparam int BLANK  = 4;
  localparam longint SUM_MAX = (64'd1 << SUM_W) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic [LUMA_W-1:0] lumaA, lumaB;
  logic              vSync, hBlank, forceFb;
  logic [SUM_W-1:0]  thrLow, thrHigh;
  logic [LINE_W-1:0] lineTol;
  logic [1:0]        mapLow, mapMed, mapHigh;
  logic [1:0]        motionLevel, modeCode;
  logic              fallback;

  int checks = 0;
  int fails  = 0;

  // bench model state
  bit     mStarted, mPhase, mValid, mHavePrev, mStable;
  longint mAcc;
  int     mLevel, mLines, mPrev, mRun;

  always #5 clk = ~clk;

  field_interp_select #(.LUMA_W(LUMA_W), .SUM_W(SUM_W), .LINE_W(LINE_W)) uut (
    .clk(clk), .rstN(rstN), .lumaA(lumaA), .lumaB(lumaB), .vSync(vSync),
    .hBlank(hBlank), .forceFb(forceFb), .thrLow(thrLow), .thrHigh(thrHigh),
    .lineTol(lineTol), .mapLow(mapLow), .mapMed(mapMed), .mapHigh(mapHigh),
    .motionLevel(motionLevel), .modeCode(modeCode), .fallback(fallback)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int grade(longint s);
    if (s < longint'(thrLow))   return 0;
    if (s >= longint'(thrHigh)) return 2;
    return 1;
  endfunction

  function automatic bit expFb();
    return forceFb || !mStable || !mValid;
  endfunction

  function automatic int expCode();
    if (expFb()) return 3;
    case (mLevel)
      1: return int'(mapMed);
      2: return int'(mapHigh);
      default: return int'(mapLow);
    endcase
  endfunction

  task automatic checkOutputs(input string tag);
    check({tag, " R2/R3 motionLevel"}, int'(motionLevel), mLevel);
    check({tag, " R5/R6/R9 fallback"}, int'(fallback), int'(expFb()));
    check({tag, " R4/R5 modeCode"}, int'(modeCode), expCode());
  endtask

  // one field of active lines; R1 sum built in the model
  task automatic genField(input int lines, input int maxDiff);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ACTIVE; p++) begin
        int a, d, b;
        @(negedge clk);
        a = int'($urandom_range(255, 0));
        d = (maxDiff == 0) ? 0 : int'($urandom_range(maxDiff, 0));
        b = (a + d <= 255) ? a + d : a - d;
        lumaA  = LUMA_W'(a);
        lumaB  = LUMA_W'(b);
        hBlank = 1'b0;
        if (mStarted) begin
          mAcc = mAcc + ((a > b) ? a - b : b - a);
          if (mAcc > SUM_MAX) mAcc = SUM_MAX;
        end
        if (l == lines / 2 && p == 0) begin
          #1 check("R3 level held mid-field", int'(motionLevel), mLevel);
        end
      end
      for (int p = 0; p < BLANK; p++) begin
        @(negedge clk);
        hBlank = 1'b1;
      end
      mLines++;
    end
  endtask

  task automatic emitVsync(input string tag);
    @(negedge clk);
    hBlank = 1'b1;
    vSync  = 1'b1;
    if (!mPhase) begin
      if (mStarted) begin
        mLevel = grade(mAcc);
        mValid = 1'b1;
      end
      mAcc = 0;
    end
    mPhase = !mPhase;
    if (mStarted) begin
      if (mHavePrev) begin
        int diff;
        diff = (mLines > mPrev) ? mLines - mPrev : mPrev - mLines;
        if (diff > int'(lineTol)) begin
          mStable = 1'b0;
          mRun = 0;
        end else begin
          if (mRun >= 1) mStable = 1'b1;
          if (mRun < 3) mRun++;
        end
      end
      mPrev = mLines;
      mHavePrev = 1'b1;
    end
    mLines = 0;
    mStarted = 1'b1;
    @(negedge clk);
    vSync = 1'b0;
    #1 checkOutputs(tag);
  endtask

  // two fields; the second vSync is a frame boundary (phase aligned by caller)
  task automatic frame(input int l0, input int l1, input int d0, input int d1, input string tag);
    genField(l0, d0);
    emitVsync({tag, " mid"});
    genField(l1, d1);
    emitVsync({tag, " boundary"});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; vSync = 1'b0; hBlank = 1'b1; forceFb = 1'b0;
    lumaA = '0; lumaB = '0;
    thrLow = SUM_W'(200); thrHigh = SUM_W'(2000); lineTol = '0;
    mapLow = 2'd0; mapMed = 2'd1; mapHigh = 2'd2;
    mStarted = 0; mPhase = 0; mValid = 0; mHavePrev = 0; mStable = 1;
    mAcc = 0; mLevel = 0; mLines = 0; mPrev = 0; mRun = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9 reset motionLevel", int'(motionLevel), 0);
    check("R9 reset fallback", int'(fallback), 1);
    check("R5 reset modeCode", int'(modeCode), 3);

    // pre-start lines with heavy difference must not count (R1)
    genField(8, 200);
    emitVsync("R9 first vsync");
    frame(8, 8, 0, 0, "R9 first frame");
    check("R9 fallback cleared after first frame", int'(fallback), 0);
    check("R1 idle frame grades LOW", int'(motionLevel), 0);

    // random frames with random maps
    for (int i = 0; i < 10; i++) begin
      int pick;
      pick = int'($urandom_range(3, 0));
      mapLow  = 2'($urandom_range(2, 0));
      mapMed  = 2'($urandom_range(2, 0));
      mapHigh = 2'($urandom_range(2, 0));
      frame(8, 8, (pick == 0) ? 0 : (pick == 1) ? 2 : (pick == 2) ? 8 : 40,
            (pick == 3) ? 40 : 3, "R2/R4 random");
    end
    mapLow = 2'd0; mapMed = 2'd1; mapHigh = 2'd2;

    // threshold edges (R2): set thresholds from the sum just before the boundary
    genField(8, 5); emitVsync("R2 edge a mid"); genField(8, 5);
    thrLow = SUM_W'(mAcc); thrHigh = SUM_W'(SUM_MAX);
    emitVsync("R2 sum equals thrLow");
    check("R2 sum==thrLow gives MEDIUM", int'(motionLevel), 1);
    genField(8, 5); emitVsync("R2 edge b mid"); genField(8, 5);
    thrLow = SUM_W'(mAcc + 1);
    emitVsync("R2 sum below thrLow");
    check("R2 sum<thrLow gives LOW", int'(motionLevel), 0);
    genField(8, 5); emitVsync("R2 edge c mid"); genField(8, 5);
    thrLow = '0; thrHigh = SUM_W'(mAcc);
    emitVsync("R2 sum equals thrHigh");
    check("R2 sum==thrHigh gives HIGH", int'(motionLevel), 2);
    genField(8, 5); emitVsync("R2 edge d mid"); genField(8, 5);
    thrHigh = SUM_W'(mAcc + 1);
    emitVsync("R2 sum below thrHigh");
    check("R2 sum<thrHigh gives MEDIUM", int'(motionLevel), 1);
    thrLow = SUM_W'(200); thrHigh = SUM_W'(2000);

    // sync instability on the same boundary as a level change (R6, R7)
    frame(8, 8, 0, 0, "R6 settle");
    frame(8, 9, 0, 60, "R6 step on boundary");
    check("R6 unstable raises fallback", int'(fallback), 1);
    check("R6 level still graded HIGH", int'(motionLevel), 2);
    genField(9, 0);
    emitVsync("R7 first match");
    check("R7 one match keeps fallback", int'(fallback), 1);
    genField(9, 0);
    emitVsync("R7 second match");
    check("R7 two matches restore stable", int'(fallback), 0);

    // tolerance (R6)
    lineTol = LINE_W'(1);
    frame(8, 8, 0, 0, "R6 within tolerance");
    check("R6 step within lineTol stays stable", int'(fallback), 0);
    lineTol = '0;

    // forced fallback in mid-field (R8)
    genField(4, 0);
    @(negedge clk);
    forceFb = 1'b1;
    #1;
    check("R8 forced fallback flag", int'(fallback), 1);
    check("R8 forced fallback code", int'(modeCode), 3);
    genField(4, 0);
    emitVsync("R8 forced vsync");
    @(negedge clk);
    forceFb = 1'b0;
    #1;
    check("R8 release restores mapped code", int'(modeCode), expCode());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule